// File: doc/BRIEF.md
# Page Write Buffer Commit Sequencer

This block sits behind the serial front end of a small nonvolatile memory. It gathers the data bytes of one write session into a 16-entry page buffer and then commits them to a 256 x 8 storage array in a single timed internal write cycle. The storage array is modelled as a register file, and a combinational read port exposes it.

A session opens with a one-cycle `sess_begin` pulse that carries a start byte address. The upper four address bits select the page, and this page stays fixed until the session closes. The lower four bits give the first in-page offset. Data bytes arrive on a valid/ready stream. A byte transfers on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is the only back-pressure. It is high only while a session is open, and it is low when no session is open and during the write cycle. The producer must hold its byte and valid until it sees ready. A `sess_end` pulse closes the session and starts the commit. A `sess_abort` pulse throws the session away.

During the commit, `busy` stays high for a parameterised number of clocks. Only the offsets that were loaded in the session are written. Every other location keeps its contents.

Top module: `page_commit_seq`

## Requirements
- R1: After reset every array location reads 8'hFF, `busy` is 0 and `in_ready` is 0.
- R2: A `sess_begin` pulse while idle opens a session. It latches page = `sess_addr[7:4]` and starting offset = `sess_addr[3:0]`. `in_ready` is 1 from the next cycle until the session closes, and the page does not change while the session is open.
- R3: Each accepted byte advances the offset by one. After offset 15 the offset returns to offset 0 of the same page, so addresses never move into the next page.
- R4: When more than 16 bytes are accepted in one session, a later byte replaces the earlier byte held at the same offset.
- R5: If at least one byte was loaded, `sess_end` makes `busy` rise on the next clock. `busy` then stays high for exactly WR_CYCLES clocks. During that time the array still reads its old contents, and the new contents are visible from the first cycle in which `busy` reads 0.
- R6: A commit writes only the offsets loaded in the session. Every other location in the page, and every location in other pages, keeps its value.
- R7: `in_ready` is 0 while idle and while `busy` is 1. In those cycles `in_valid` and `sess_begin` have no effect.
- R8: `sess_abort` during an open session discards all loaded bytes, closes the session and starts no write. `busy` stays 0 and the array is unchanged. An abort takes priority over a `sess_end` or a byte in the same cycle.
- R9: A `sess_end` with no byte loaded closes the session, never raises `busy` and leaves the array unchanged.
- R10: A byte accepted in the same cycle as `sess_end` belongs to the session and is committed.
- R11: `rd_data` shows the array content at `rd_addr` in the same cycle, with no clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_begin | input | 1 | One-cycle pulse that opens a session |
| sess_addr | input | 8 | Start byte address, sampled with `sess_begin` |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Data byte |
| sess_end | input | 1 | One-cycle pulse that closes the session and requests the commit |
| sess_abort | input | 1 | One-cycle pulse that discards the session |
| busy | output | 1 | Internal write cycle in progress |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |

## Verification
The bench targets these corner cases:
- Offset wrap at the page end. A design that carried into the next page would corrupt the neighbouring page.
- A session longer than 16 bytes. A design that stalled or dropped bytes would leave the first offsets holding stale values.
- Partial pages. A design that wrote all 16 entries would overwrite unloaded locations with stale buffer data.
- Abort in the same cycle as end, and end with no data. A wrong priority or a missing empty check would show as a spurious `busy` or a changed array.
- Traffic sent while idle or busy, and a byte that arrives together with end. A design that leaked or lost these bytes would show the wrong array contents.
- The exact `busy` length, and the old data read during `busy`. These expose an off-by-one in the timer or an early commit.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  localparam int DEF_ADDR_W    = 8;
  localparam int DEF_DATA_W    = 8;
  localparam int DEF_OFF_W     = 4;
  localparam int DEF_WR_CYCLES = 40;
endpackage

// File: rtl/pcs_commit_ctl.sv
module pcs_commit_ctl
  import pcs_pkg::*;
#(
  parameter int WR_CYCLES = DEF_WR_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_begin_i,
  input  logic sess_end_i,
  input  logic sess_abort_i,
  input  logic push_i,
  input  logic mask_any_i,
  output logic open_o,
  output logic sess_open_o,
  output logic clear_o,
  output logic commit_o,
  output logic busy_o,
  output logic in_ready_o
);
  localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic has_data;

  assign has_data = mask_any_i | push_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (sess_begin_i) state_d = ST_LOAD;
      ST_LOAD: begin
        if (sess_abort_i)    state_d = ST_IDLE;
        else if (sess_end_i) state_d = has_data ? ST_WRITE : ST_IDLE;
      end
      ST_WRITE: if (cnt_q == LAST) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_WRITE) cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign open_o      = (state_q == ST_IDLE) && sess_begin_i;
  assign sess_open_o = (state_q == ST_LOAD);
  assign in_ready_o  = (state_q == ST_LOAD);
  assign busy_o      = (state_q == ST_WRITE);
  assign commit_o    = (state_q == ST_WRITE) && (cnt_q == LAST);
  assign clear_o     = ((state_q == ST_LOAD) && sess_abort_i) || commit_o;

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready_o);  // R7
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_open_o && sess_abort_i) |=> (!busy_o && !in_ready_o));  // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_open_o && sess_end_i && !sess_abort_i && !mask_any_i && !push_i)
      |=> (!busy_o && !in_ready_o));  // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_open_o && sess_end_i && !sess_abort_i && push_i) |=> busy_o);  // R10
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(cnt_q) == LAST);  // R5
endmodule

// File: rtl/pcs_page_buf.sv
module pcs_page_buf
  import pcs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFF_W  = DEF_OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open_i,
  input  logic                     sess_open_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     push_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     clear_i,
  output logic [ADDR_W-OFF_W-1:0]  page_o,
  output logic [(1<<OFF_W)-1:0]    mask_o,
  output logic [(1<<OFF_W)*DATA_W-1:0] bytes_o
);
  localparam int NB   = 1 << OFF_W;
  localparam int PG_W = ADDR_W - OFF_W;

  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [NB-1:0]    mask_q;
  logic             take;

  assign take = push_i && !clear_i && !open_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (open_i) begin
      page_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
      mask_q <= '0;
    end else if (clear_i) begin
      mask_q <= '0;
    end else if (take) begin
      mask_q[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1;
    end
  end

  for (genvar e = 0; e < NB; e++) begin : g_entry
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ent_q <= '0;
      else if (take && off_q == OFF_W'(e))  ent_q <= data_i;
    end
    assign bytes_o[e*DATA_W +: DATA_W] = ent_q;
  end

  assign page_o = page_q;
  assign mask_o = mask_q;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_open_i && $past(sess_open_i)) |-> $stable(page_q));  // R2
  AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && off_q == {OFF_W{1'b1}}) |=> (off_q == '0));  // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (mask_q == '0));  // R8
endmodule

// File: rtl/pcs_array.sv
module pcs_array
  import pcs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFF_W  = DEF_OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_i,
  input  logic [ADDR_W-OFF_W-1:0]      page_i,
  input  logic [(1<<OFF_W)-1:0]        mask_i,
  input  logic [(1<<OFF_W)*DATA_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = 1 << OFF_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '1;
    end else if (commit_i) begin
      for (int o = 0; o < NB; o++) begin
        if (mask_i[o]) mem_q[{page_i, OFF_W'(o)}] <= bytes_i[o*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_ARRAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ((rd_addr_i != $past(rd_addr_i)) || $stable(rd_data_o)));  // R6
endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int OFF_W     = DEF_OFF_W,
  parameter int WR_CYCLES = DEF_WR_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_begin,
  input  logic [ADDR_W-1:0] sess_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              sess_end,
  input  logic              sess_abort,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NB   = 1 << OFF_W;
  localparam int PG_W = ADDR_W - OFF_W;

  logic              open_s, sess_open_s, clear_s, commit_s, push_s;
  logic [PG_W-1:0]   page_s;
  logic [NB-1:0]     mask_s;
  logic [NB*DATA_W-1:0] bytes_s;

  assign push_s = in_valid && in_ready;

  pcs_commit_ctl #(.WR_CYCLES(WR_CYCLES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sess_begin_i (sess_begin),
    .sess_end_i   (sess_end),
    .sess_abort_i (sess_abort),
    .push_i       (push_s),
    .mask_any_i   (|mask_s),
    .open_o       (open_s),
    .sess_open_o  (sess_open_s),
    .clear_o      (clear_s),
    .commit_o     (commit_s),
    .busy_o       (busy),
    .in_ready_o   (in_ready)
  );

  pcs_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_i      (open_s),
    .sess_open_i (sess_open_s),
    .addr_i      (sess_addr),
    .push_i      (push_s),
    .data_i      (in_data),
    .clear_i     (clear_s),
    .page_o      (page_s),
    .mask_o      (mask_s),
    .bytes_o     (bytes_s)
  );

  pcs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit_s),
    .page_i    (page_s),
    .mask_i    (mask_s),
    .bytes_i   (bytes_s),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit_s |-> (mask_s != '0));  // R9
endmodule

// File: tb/page_commit_seq_test.sv
module page_commit_seq_test;
  localparam int WR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess_begin = 1'b0, in_valid = 1'b0, sess_end = 1'b0, sess_abort = 1'b0;
  logic [7:0] sess_addr = '0, in_data = '0, rd_addr = '0;
  logic in_ready, busy;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  logic [7:0] model [256];
  logic [7:0] pend [16];
  logic [15:0] pmask;
  logic [3:0] ppage, poff;

  always #5 clk = ~clk;

  page_commit_seq #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .sess_begin(sess_begin), .sess_addr(sess_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .sess_end(sess_end), .sess_abort(sess_abort), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic scan(input string req);
    int bad = 0;
    int first_a = -1;
    logic [7:0] fa = '0, fe = '0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd_addr = 8'(a);
      #1;
      if (rd_data !== model[a]) begin
        bad++;
        if (first_a < 0) begin first_a = a; fa = rd_data; fe = model[a]; end
      end
    end
    chk(bad == 0, req, {first_a[7:0], fa}, {first_a[7:0], fe});
    tick();
  endtask

  task automatic open_sess(input logic [7:0] a);
    sess_begin = 1'b1; sess_addr = a;
    tick();
    sess_begin = 1'b0;
    ppage = a[7:4]; poff = a[3:0]; pmask = '0;
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    tick();
    in_valid = 1'b0;
    pend[poff] = d; pmask[poff] = 1'b1; poff = poff + 1'b1;
  endtask

  // end the session, measure busy, probe old data during busy, then update model
  task automatic end_commit(input logic [7:0] probe, input logic disturb);
    int n = 0;
    sess_end = 1'b1;
    tick();
    sess_end = 1'b0;
    chk(busy === 1'b1, "R5 busy rises", busy, 1);
    rd_addr = probe;
    #1;
    chk(rd_data === model[probe], "R5 old data during busy", rd_data, model[probe]);
    if (disturb) begin
      in_valid = 1'b1; in_data = 8'hEE; sess_begin = 1'b1; sess_addr = 8'hA3;
      chk(in_ready === 1'b0, "R7 ready low while busy", in_ready, 0);
    end
    while (busy === 1'b1 && n < 1000) begin
      n++;
      tick();
    end
    in_valid = 1'b0; sess_begin = 1'b0;
    chk(n == WR, "R5 busy length", n, WR);
    for (int o = 0; o < 16; o++) if (pmask[o]) model[{ppage, 4'(o)}] = pend[o];
    rd_addr = probe;
    #1;
    chk(rd_data === model[probe], "R5 new data after busy", rd_data, model[probe]);
    tick();
    chk(in_ready === 1'b0 && busy === 1'b0, "R7 idle after commit", {in_ready, busy}, 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(in_ready === 1'b0, "R1 ready after reset", in_ready, 0);
    rd_addr = 8'h9C; #1;
    chk(rd_data === 8'hFF, "R11 combinational read", rd_data, 8'hFF);
    scan("R1 array erased");
  endtask

  task automatic t_single();
    open_sess(8'h35);
    chk(in_ready === 1'b1, "R2 ready in session", in_ready, 1);
    push(8'hA5);
    end_commit(8'h35, 1'b0);
    scan("R6 single byte write");
  endtask

  task automatic t_wrap();
    open_sess(8'h7E);
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    end_commit(8'h70, 1'b0);
    scan("R3 offset wraps in page");
  endtask

  task automatic t_overflow();
    open_sess(8'h20);
    for (int i = 0; i < 18; i++) push(8'(8'h40 + i));
    end_commit(8'h21, 1'b0);
    rd_addr = 8'h20; #1;
    chk(rd_data === 8'h50, "R4 overwrite offset 0", rd_data, 8'h50);
    scan("R4 overflow session");
  endtask

  task automatic t_abort();
    open_sess(8'h50);
    push(8'h77); push(8'h78);
    sess_abort = 1'b1;
    tick();
    sess_abort = 1'b0;
    chk(busy === 1'b0 && in_ready === 1'b0, "R8 abort closes", {busy, in_ready}, 0);
    open_sess(8'h58);
    push(8'h66);
    sess_abort = 1'b1; sess_end = 1'b1; in_valid = 1'b1; in_data = 8'h67;
    tick();
    sess_abort = 1'b0; sess_end = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < WR + 2; i++) begin
      chk(busy === 1'b0, "R8 abort beats end", busy, 0);
      tick();
    end
    scan("R8 abort leaves array");
  endtask

  task automatic t_empty();
    open_sess(8'h61);
    sess_end = 1'b1;
    tick();
    sess_end = 1'b0;
    chk(busy === 1'b0 && in_ready === 1'b0, "R9 empty session", {busy, in_ready}, 0);
    tick();
    chk(busy === 1'b0, "R9 busy never rises", busy, 0);
    scan("R9 empty leaves array");
  endtask

  task automatic t_ignored();
    in_valid = 1'b1; in_data = 8'hBB;
    tick(); tick(); tick();
    chk(in_ready === 1'b0, "R7 ready low while idle", in_ready, 0);
    in_valid = 1'b0;
    open_sess(8'h93);
    push(8'h11);
    end_commit(8'h93, 1'b1);
    scan("R7 idle and busy traffic ignored");
  endtask

  task automatic t_end_with_byte();
    open_sess(8'hCF);
    push(8'h5A);
    in_valid = 1'b1; in_data = 8'hC3; sess_end = 1'b1;
    pend[poff] = 8'hC3; pmask[poff] = 1'b1; poff = poff + 1'b1;
    tick();
    in_valid = 1'b0; sess_end = 1'b0;
    chk(busy === 1'b1, "R10 busy with end byte", busy, 1);
    for (int i = 0; i < WR; i++) tick();
    for (int o = 0; o < 16; o++) if (pmask[o]) model[{ppage, 4'(o)}] = pend[o];
    rd_addr = 8'hC0; #1;
    chk(rd_data === 8'hC3, "R10 end byte committed", rd_data, 8'hC3);
    scan("R10 array after end byte");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;
    pmask = '0; ppage = '0; poff = '0;
    for (int o = 0; o < 16; o++) pend[o] = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_abort();
    t_empty();
    t_ignored();
    t_end_with_byte();
    report();
  end
endmodule